// File: doc/BRIEF.md
# One-Way ROM Access Selector

This block sits in front of a ROM and decides which of two requesters may read it: the integrity checker that sweeps the ROM after reset, or the system bus that serves normal fetches. A 4-bit encoded select input names the owner. The checker owns the ROM out of reset. Once the bus has been granted, ownership is permanent. A glitch that points the select back at the checker, or that drives any code other than the two legal ones, raises a fatal alert. The alert stays high until reset.

Each requester has a valid/ready request channel. The ready signal of a side is the grant. A request completes in the cycle where valid and ready are both high, and a requester holds its valid and address until that cycle. The ROM answers one cycle later. The read data and the response valid are returned only to the side that issued the request. The response channels have no back-pressure, so each requester must accept a response in the cycle it appears. The bus address reaches the ROM on two redundant paths, one for the descrambling index and one for the storage index, so that neither can be faulted alone. The bus response valid is held low whenever any consistency error is present, whether it is one of this block's own alerts or one reported by a neighbour on `int_err_i`.

Top module: `rom_access_mux`

## Requirements
- R1: While reset is low and in the first cycle after it, both alerts, both response valids and both response data buses are 0, and the registered select copy starts as the checker code.
- R2: When `sel_i` is the checker code 4'b0101 and the bus code has never been seen since reset, `chk_req_ready_o` is 1, `bus_req_ready_o` is 0, and `rom_req_o` equals `chk_req_valid_i`.
- R3: When `sel_i` is the bus code 4'b1010, `bus_req_ready_o` is 1, `chk_req_ready_o` is 0, and `rom_req_o` equals `bus_req_valid_i`.
- R4: Any `sel_i` value other than 4'b0101 or 4'b1010 grants neither side, and it sets `alert_invalid_o` on the next clock edge.
- R5: After the bus code has been seen, a return of `sel_i` to the checker code sets `alert_revert_o` on the next clock edge, and it leaves the checker without a grant. Both the live select and its registered copy are watched for this reversion.
- R6: Read data on `rom_rdata_i` in the cycle after a completed request is forwarded only to the side that issued it. The response valid of that side is 1 in that cycle. The other side sees valid 0 and data 0.
- R7: `bus_rsp_valid_o` is 0 in every cycle where `alert_invalid_o`, `alert_revert_o` or `int_err_i` is 1.
- R8: Whenever `rom_req_o` is 1, `rom_scr_addr_o` and `rom_mem_addr_o` both equal the address of the granted side.
- R9: Once set, `alert_invalid_o` and `alert_revert_o` stay 1 until reset, whatever `sel_i` does afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 4 | Encoded owner select (4'b0101 checker, 4'b1010 bus) |
| int_err_i | input | 1 | Consistency error reported by a neighbouring block |
| chk_req_valid_i | input | 1 | Checker read request valid |
| chk_req_ready_o | output | 1 | Checker granted |
| chk_addr_i | input | ADDR_W | Checker word address |
| chk_rsp_valid_o | output | 1 | Checker read response valid |
| chk_rsp_data_o | output | DATA_W | Checker read data |
| bus_req_valid_i | input | 1 | Bus read request valid |
| bus_req_ready_o | output | 1 | Bus granted |
| bus_addr_i | input | ADDR_W | Bus word address |
| bus_rsp_valid_o | output | 1 | Bus read response valid, gated by errors |
| bus_rsp_data_o | output | DATA_W | Bus read data |
| rom_req_o | output | 1 | ROM read strobe |
| rom_scr_addr_o | output | ADDR_W | Address copy for the descrambling index |
| rom_mem_addr_o | output | ADDR_W | Address copy for the storage index |
| rom_rdata_i | input | DATA_W | ROM read data, one cycle after the strobe |
| alert_invalid_o | output | 1 | Sticky fatal alert: illegal select code |
| alert_revert_o | output | 1 | Sticky fatal alert: ownership returned to checker |

## Verification
The bench goes after the ownership hand-over and the glitches around it. It drives checker reads, then the switch to the bus, then an illegal code, and, after a fresh reset, a jump back to the checker. A design that decoded the select loosely would grant on a one-bit-flipped code and never alarm. A design that tracked only the current select would let the checker reclaim the ROM silently. The bench also makes a response land in the cycle after `int_err_i` or an alert rises. A design that gated only on its own alerts, or that checked the gate one cycle late, would hand the bus a valid word while an error is present. Every cycle it compares both data buses against a behavioural model. A routing error that leaks ROM data to the idle side, or that returns it in the wrong cycle, shows up as a data mismatch.

// File: rtl/rom_mux_pkg.sv
package rom_mux_pkg;
  localparam int SEL_W = 4;
  typedef logic [SEL_W-1:0] sel_t;
  // Legal codes, Hamming distance 4 from each other.
  localparam sel_t SEL_CHK = 4'b0101;
  localparam sel_t SEL_BUS = 4'b1010;

  typedef enum logic [1:0] {
    OWN_NONE = 2'b00,
    OWN_CHK  = 2'b01,
    OWN_BUS  = 2'b10
  } owner_e;
endpackage

// File: rtl/rom_mux_sel_decode.sv
module rom_mux_sel_decode
  import rom_mux_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  sel_t sel_i,
  output logic grant_chk_o,
  output logic grant_bus_o,
  output logic alert_invalid_o,
  output logic alert_revert_o
);
  sel_t sel_q;
  logic bus_seen_q;     // bus code seen on live select
  logic bus_seen_qq;    // bus code seen on registered select
  logic live_is_bus, live_is_chk, reg_is_bus, reg_is_chk;
  logic bad_code, revert_live, revert_reg;
  logic inv_q, rev_q;

  always_comb begin
    live_is_bus = (sel_i == SEL_BUS);
    live_is_chk = (sel_i == SEL_CHK);
    reg_is_bus  = (sel_q == SEL_BUS);
    reg_is_chk  = (sel_q == SEL_CHK);
    bad_code    = (!live_is_bus && !live_is_chk) || (!reg_is_bus && !reg_is_chk);
    revert_live = live_is_chk && bus_seen_q;
    revert_reg  = reg_is_chk && bus_seen_qq;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q       <= SEL_CHK;
      bus_seen_q  <= 1'b0;
      bus_seen_qq <= 1'b0;
      inv_q       <= 1'b0;
      rev_q       <= 1'b0;
    end else begin
      sel_q       <= sel_i;
      bus_seen_q  <= bus_seen_q | live_is_bus;
      bus_seen_qq <= bus_seen_qq | reg_is_bus;
      inv_q       <= inv_q | bad_code;
      rev_q       <= rev_q | revert_live | revert_reg;
    end
  end

  assign grant_chk_o     = live_is_chk && !bus_seen_q;
  assign grant_bus_o     = live_is_bus;
  assign alert_invalid_o = inv_q;
  assign alert_revert_o  = rev_q;
endmodule

// File: rtl/rom_mux_addr_path.sv
module rom_mux_addr_path #(
  parameter int ADDR_W = 13
) (
  input  logic              use_bus_i,
  input  logic [ADDR_W-1:0] chk_addr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_comb begin
    if (use_bus_i) addr_o = bus_addr_i;
    else           addr_o = chk_addr_i;
  end
endmodule

// File: rtl/rom_mux_rsp_route.sv
module rom_mux_rsp_route
  import rom_mux_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_chk_i,
  input  logic              issue_bus_i,
  input  logic              err_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              chk_valid_o,
  output logic [DATA_W-1:0] chk_data_o,
  output logic              bus_valid_o,
  output logic [DATA_W-1:0] bus_data_o
);
  owner_e own_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          own_q <= OWN_NONE;
    else if (issue_bus_i) own_q <= OWN_BUS;
    else if (issue_chk_i) own_q <= OWN_CHK;
    else                  own_q <= OWN_NONE;
  end

  always_comb begin
    chk_valid_o = (own_q == OWN_CHK);
    bus_valid_o = (own_q == OWN_BUS) && !err_i;
    chk_data_o  = (own_q == OWN_CHK) ? rdata_i : '0;
    bus_data_o  = (own_q == OWN_BUS) ? rdata_i : '0;
  end
endmodule

// File: rtl/rom_access_mux.sv
module rom_access_mux
  import rom_mux_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        sel_i,
  input  logic              int_err_i,
  input  logic              chk_req_valid_i,
  output logic              chk_req_ready_o,
  input  logic [ADDR_W-1:0] chk_addr_i,
  output logic              chk_rsp_valid_o,
  output logic [DATA_W-1:0] chk_rsp_data_o,
  input  logic              bus_req_valid_i,
  output logic              bus_req_ready_o,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic              bus_rsp_valid_o,
  output logic [DATA_W-1:0] bus_rsp_data_o,
  output logic              rom_req_o,
  output logic [ADDR_W-1:0] rom_scr_addr_o,
  output logic [ADDR_W-1:0] rom_mem_addr_o,
  input  logic [DATA_W-1:0] rom_rdata_i,
  output logic              alert_invalid_o,
  output logic              alert_revert_o
);
  localparam int N_PATHS = 2;

  logic grant_chk, grant_bus, issue_chk, issue_bus, err_any;
  logic [N_PATHS-1:0][ADDR_W-1:0] path_addr;

  rom_mux_sel_decode u_dec (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .sel_i           (sel_i),
    .grant_chk_o     (grant_chk),
    .grant_bus_o     (grant_bus),
    .alert_invalid_o (alert_invalid_o),
    .alert_revert_o  (alert_revert_o)
  );

  assign issue_chk = grant_chk && chk_req_valid_i;
  assign issue_bus = grant_bus && bus_req_valid_i;

  // Two independent address copies toward the ROM.
  for (genvar p = 0; p < N_PATHS; p++) begin : g_path
    rom_mux_addr_path #(.ADDR_W(ADDR_W)) u_path (
      .use_bus_i  (grant_bus),
      .chk_addr_i (chk_addr_i),
      .bus_addr_i (bus_addr_i),
      .addr_o     (path_addr[p])
    );
  end

  assign err_any = alert_invalid_o | alert_revert_o | int_err_i;

  rom_mux_rsp_route #(.DATA_W(DATA_W)) u_rsp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .issue_chk_i (issue_chk),
    .issue_bus_i (issue_bus),
    .err_i       (err_any),
    .rdata_i     (rom_rdata_i),
    .chk_valid_o (chk_rsp_valid_o),
    .chk_data_o  (chk_rsp_data_o),
    .bus_valid_o (bus_rsp_valid_o),
    .bus_data_o  (bus_rsp_data_o)
  );

  assign chk_req_ready_o = grant_chk;
  assign bus_req_ready_o = grant_bus;
  assign rom_req_o       = issue_chk | issue_bus;
  assign rom_scr_addr_o  = path_addr[0];
  assign rom_mem_addr_o  = path_addr[1];
endmodule

// File: rtl/rom_access_mux_chk.sv
module rom_access_mux_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        sel_i,
  input logic              int_err_i,
  input logic              chk_req_valid_i,
  input logic              chk_req_ready_o,
  input logic              bus_req_valid_i,
  input logic              bus_req_ready_o,
  input logic              chk_rsp_valid_o,
  input logic              bus_rsp_valid_o,
  input logic              rom_req_o,
  input logic [ADDR_W-1:0] rom_scr_addr_o,
  input logic [ADDR_W-1:0] rom_mem_addr_o,
  input logic              alert_invalid_o,
  input logic              alert_revert_o
);
  assert_bus_grant_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_ready_o |-> (sel_i == 4'b1010 && !chk_req_ready_o));
  assert_chk_grant_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_req_ready_o |-> (sel_i == 4'b0101));
  assert_bad_code_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i != 4'b0101 && sel_i != 4'b1010) |=> alert_invalid_o);
  assert_no_reclaim_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_revert_o |-> !chk_req_ready_o);
  assert_one_rsp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(chk_rsp_valid_o && bus_rsp_valid_o));
  assert_bus_rsp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_valid_i && bus_req_ready_o) |=>
      (bus_rsp_valid_o || alert_invalid_o || alert_revert_o || int_err_i));
  assert_err_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alert_invalid_o || alert_revert_o || int_err_i) |-> !bus_rsp_valid_o);
  assert_addr_twin_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_req_o |-> (rom_scr_addr_o == rom_mem_addr_o));
  assert_inv_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_invalid_o |=> alert_invalid_o);
  assert_rev_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_revert_o |=> alert_revert_o);
endmodule

bind rom_access_mux rom_access_mux_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .sel_i           (sel_i),
  .int_err_i       (int_err_i),
  .chk_req_valid_i (chk_req_valid_i),
  .chk_req_ready_o (chk_req_ready_o),
  .bus_req_valid_i (bus_req_valid_i),
  .bus_req_ready_o (bus_req_ready_o),
  .chk_rsp_valid_o (chk_rsp_valid_o),
  .bus_rsp_valid_o (bus_rsp_valid_o),
  .rom_req_o       (rom_req_o),
  .rom_scr_addr_o  (rom_scr_addr_o),
  .rom_mem_addr_o  (rom_mem_addr_o),
  .alert_invalid_o (alert_invalid_o),
  .alert_revert_o  (alert_revert_o)
);

// File: tb/rom_access_mux_bench.sv
module rom_access_mux_bench;
  localparam int AW = 13;
  localparam int DW = 32;
  localparam logic [3:0] CHK = 4'b0101;
  localparam logic [3:0] BUS = 4'b1010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] sel = CHK;
  logic int_err = 1'b0;
  logic chk_v = 1'b0, bus_v = 1'b0;
  logic [AW-1:0] chk_a = '0, bus_a = '0;
  logic [DW-1:0] rdata = '0;
  logic chk_rdy, bus_rdy, chk_rv, bus_rv, rom_req, a_inv, a_rev;
  logic [DW-1:0] chk_d, bus_d;
  logic [AW-1:0] scr_a, mem_a;

  int checks = 0;
  int fails = 0;

  // reference state
  bit m_seen_bus, m_inv, m_rev, m_pend_chk, m_pend_bus, m_first;

  always #2.5 clk = ~clk;

  rom_access_mux #(.ADDR_W(AW), .DATA_W(DW)) u_rom_access_mux (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .int_err_i(int_err),
    .chk_req_valid_i(chk_v), .chk_req_ready_o(chk_rdy), .chk_addr_i(chk_a),
    .chk_rsp_valid_o(chk_rv), .chk_rsp_data_o(chk_d),
    .bus_req_valid_i(bus_v), .bus_req_ready_o(bus_rdy), .bus_addr_i(bus_a),
    .bus_rsp_valid_o(bus_rv), .bus_rsp_data_o(bus_d),
    .rom_req_o(rom_req), .rom_scr_addr_o(scr_a), .rom_mem_addr_o(mem_a),
    .rom_rdata_i(rdata), .alert_invalid_o(a_inv), .alert_revert_o(a_rev)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit e_chk_rdy, e_bus_rdy, e_req, e_err;
    logic [AW-1:0] e_addr;
    e_chk_rdy = (sel == CHK) && !m_seen_bus;
    e_bus_rdy = (sel == BUS);
    e_req = (e_chk_rdy && chk_v) || (e_bus_rdy && bus_v);
    e_addr = e_bus_rdy ? bus_a : chk_a;
    e_err = m_inv || m_rev || int_err;
    if (!rst_n || m_first) begin
      check("R1 alert_invalid", a_inv, 0);
      check("R1 alert_revert", a_rev, 0);
      check("R1 rsp valids", {chk_rv, bus_rv}, 0);
      check("R1 rsp data", {chk_d, bus_d}, 0);
    end
    if (!rst_n) return;
    check(sel == BUS ? "R3 bus ready" : "R2 bus ready", bus_rdy, e_bus_rdy);
    check(m_seen_bus ? "R5 chk ready" : "R2 chk ready", chk_rdy, e_chk_rdy);
    check((sel != CHK && sel != BUS) ? "R4 rom_req" : "R2/R3 rom_req", rom_req, e_req);
    if (e_req) begin
      check("R8 scr addr", scr_a, e_addr);
      check("R8 mem addr", mem_a, e_addr);
    end
    check("R4 R9 alert_invalid", a_inv, m_inv);
    check("R5 R9 alert_revert", a_rev, m_rev);
    check("R6 chk rsp valid", chk_rv, m_pend_chk);
    check("R6 chk rsp data", chk_d, m_pend_chk ? rdata : '0);
    check(e_err ? "R7 bus rsp valid" : "R6 bus rsp valid", bus_rv, m_pend_bus && !e_err);
    check("R6 bus rsp data", bus_d, m_pend_bus ? rdata : '0);
  endtask

  task automatic update();
    bit g_chk, g_bus;
    if (!rst_n) begin
      m_seen_bus = 0; m_inv = 0; m_rev = 0; m_pend_chk = 0; m_pend_bus = 0; m_first = 1;
      return;
    end
    m_first = 0;
    g_chk = (sel == CHK) && !m_seen_bus;
    g_bus = (sel == BUS);
    if (sel != CHK && sel != BUS) m_inv = 1;
    if (sel == CHK && m_seen_bus) m_rev = 1;
    if (g_bus) m_seen_bus = 1;
    m_pend_chk = g_chk && chk_v;
    m_pend_bus = g_bus && bus_v;
  endtask

  task automatic step(logic [3:0] s, bit cv, logic [AW-1:0] ca, bit bv,
                      logic [AW-1:0] ba, bit ie, logic [DW-1:0] rd);
    @(negedge clk);
    sel = s; chk_v = cv; chk_a = ca; bus_v = bv; bus_a = ba; int_err = ie; rdata = rd;
    #1;
    compare();
    @(posedge clk);
    update();
  endtask

  task automatic do_reset();
    rst_n = 0;
    for (int i = 0; i < 3; i++) step(CHK, 0, '0, 0, '0, 0, 32'hDEAD_0000 + i);
    rst_n = 1;
  endtask

  initial begin
    fork
      begin
        #100000;
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    join_none

    update();
    // R1 reset; R2 checker sweep
    do_reset();
    for (int i = 0; i < 8; i++)
      step(CHK, 1, AW'(i * 3), (i % 2) == 1, AW'(100 + i), 0, 32'hC000_0000 + i);
    step(CHK, 0, '0, 1, 13'h55, 0, 32'h1234_5678);
    // R3 hand-over and bus reads, R6 routing
    for (int i = 0; i < 8; i++)
      step(BUS, (i % 3) == 0, AW'(7), (i % 2) == 0, AW'(200 + i), 0, 32'hB000_0000 + i);
    // R7 neighbour error gates bus response
    step(BUS, 0, '0, 1, 13'h10, 0, 32'hA1);
    step(BUS, 0, '0, 1, 13'h11, 1, 32'hA2);
    step(BUS, 0, '0, 0, 13'h12, 1, 32'hA3);
    step(BUS, 0, '0, 1, 13'h13, 0, 32'hA4);
    step(BUS, 0, '0, 0, 13'h14, 0, 32'hA5);
    // R4 invalid code (one bit off bus code), then R9 sticky, R7 gating
    step(BUS, 0, '0, 1, 13'h20, 0, 32'hA6);
    step(4'b1011, 1, 13'h5, 1, 13'h21, 0, 32'hA7);
    for (int i = 0; i < 6; i++)
      step(BUS, 0, '0, 1, AW'(300 + i), 0, 32'hE000_0000 + i);
    // R5 reversion after fresh reset
    do_reset();
    step(CHK, 1, 13'h1, 0, '0, 0, 32'h11);
    step(BUS, 0, '0, 1, 13'h2, 0, 32'h22);
    step(BUS, 1, 13'h3, 1, 13'h3, 0, 32'h33);
    step(CHK, 1, 13'h4, 1, 13'h4, 0, 32'h44);
    for (int i = 0; i < 5; i++)
      step(CHK, 1, AW'(i), 0, '0, 0, 32'hF000_0000 + i);
    step(BUS, 0, '0, 1, 13'h9, 0, 32'h99);
    step(BUS, 0, '0, 0, 13'h9, 0, 32'h9A);
    // all-zero and all-one codes after reset
    do_reset();
    step(4'b0000, 1, 13'h1, 1, 13'h2, 0, 32'h5);
    step(4'b1111, 1, 13'h1, 1, 13'h2, 0, 32'h6);
    step(CHK, 1, 13'h3, 0, '0, 0, 32'h7);
    step(CHK, 0, '0, 0, '0, 0, 32'h8);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule